// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state. After reset is released it drives a short, fixed series of commands on a simplified command bus: an active-low chip select, row strobe, column strobe and write enable, plus bank and address lines. The series is a power-up settle period, a precharge of every bank, a number of auto-refresh commands, and one mode-register load. When the last wait has elapsed, it raises a done flag that tells the normal command engine it may start.

Each wait is a parameter counted in controller clock cycles. A wait parameter gives the number of NOP cycles placed after a command, so two commands are always that many cycles plus one apart. All parameters must be at least 1. The done flag and the idle bus both stay in place until the next reset. A reset that arrives in the middle of the series starts it again from the beginning.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, the bus carries NOP, `addr` and `ba` are zero and `init_done` is low. A reset at any point in the series restarts it from the power-up wait.
- R2: A NOP is {cs_n, ras_n, cas_n, we_n} = 4'b0111 with `addr` and `ba` zero. A NOP is driven in every cycle that does not carry a command.
- R3: After reset is released, the first PWR_CYC clock edges each leave a NOP on the bus. The edge after them puts the precharge on the bus.
- R4: The precharge is encoded 4'b0010 with addr bit 10 high, all other address bits zero and `ba` zero. This selects all banks.
- R5: Exactly RP_CYC NOP cycles follow the precharge before the first auto-refresh.
- R6: An auto-refresh is encoded 4'b0001 with `addr` and `ba` zero. Exactly NUM_REF of them are issued, and each is followed by RFC_CYC NOP cycles.
- R7: The mode-register load is encoded 4'b0000 with `addr` equal to MODE_VAL and `ba` equal to MODE_BA. It comes directly after the last refresh wait, and only once all refreshes have been issued.
- R8: The mode-register load is followed by MRD_CYC NOP cycles. On the next cycle `init_done` goes high.
- R9: Once high, `init_done` stays high and the bus stays at NOP until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines, bit 10 is the all-banks flag |
| init_done | output | 1 | Series complete, held until reset |

## Verification
The bus outputs and `init_done` are decoded from one state register. Each result is therefore due on the first clock edge after the cycle that causes it, and reset takes effect at once with no edge. The bench releases reset on a falling edge and then checks every cycle, sampling on each following falling edge. It builds the expected command for cycle n from the wait parameters alone: PWR_CYC NOPs, then one cycle per command, each followed by its own count of NOPs. Every comparison therefore lands exactly one rising edge after the previous one. The reset check samples 1 ns after `rst_n` falls, with no edge in between.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 3,
  parameter int CNT_W   = 16,
  parameter int PWR_CYC = 200,
  parameter int RP_CYC  = 4,
  parameter int RFC_CYC = 20,
  parameter int MRD_CYC = 4,
  parameter int NUM_REF = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(12'h032),
  parameter logic [BA_W-1:0]   MODE_BA  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int AP_BIT = 10;
  localparam int RW = $clog2(NUM_REF + 1);
  localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(RFC_CYC - 1);
  localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(MRD_CYC - 1);
  localparam logic [RW-1:0]    REF_N  = RW'(NUM_REF);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_PRE, S_WRP, S_REF, S_WRFC, S_MRS, S_WMRD, S_DONE
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    refs;
  logic [3:0]       cmd;
  wire              cnt_end = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      refs <= '0;
    end else begin
      case (st)
        S_IDLE: begin st <= S_PWR; cnt <= PWR_LD; end
        S_PWR:  if (cnt_end) st <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE:  begin st <= S_WRP; cnt <= RP_LD; end
        S_WRP:  if (cnt_end) st <= S_REF; else cnt <= cnt - 1'b1;
        S_REF:  begin st <= S_WRFC; cnt <= RFC_LD; refs <= refs + 1'b1; end
        S_WRFC: if (cnt_end) st <= (refs == REF_N) ? S_MRS : S_REF;
                else cnt <= cnt - 1'b1;
        S_MRS:  begin st <= S_WMRD; cnt <= MRD_LD; end
        S_WMRD: if (cnt_end) st <= S_DONE; else cnt <= cnt - 1'b1;
        S_DONE: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd = (st == S_PRE) ? C_PRE :
               (st == S_REF) ? C_REF :
               (st == S_MRS) ? C_MRS : C_NOP;
  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign addr = (st == S_PRE) ? (ADDR_W'(1) << AP_BIT) :
                (st == S_MRS) ? MODE_VAL : '0;
  assign ba        = (st == S_MRS) ? MODE_BA : '0;
  assign init_done = (st == S_DONE);

  wire bus_nop = ({cs_n, ras_n, cas_n, we_n} == C_NOP);
  wire bus_pre = ({cs_n, ras_n, cas_n, we_n} == C_PRE);
  wire bus_ref = ({cs_n, ras_n, cas_n, we_n} == C_REF);
  wire bus_mrs = ({cs_n, ras_n, cas_n, we_n} == C_MRS);

  logic [RW:0] seen_ref;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_ref <= '0;
    else if (bus_ref) seen_ref <= seen_ref + 1'b1;
  end

  // R4
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pre |-> addr[AP_BIT]);

  // R5
  pre_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pre |=> bus_nop);

  // R7
  mrs_after_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mrs |-> (seen_ref == (RW+1)'(NUM_REF)));

  // R8
  done_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(bus_nop));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && bus_nop));
endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int AW = 13, BW = 3;
  localparam int P = 8, RP = 3, RFC = 5, MRD = 4, NR = 2;
  localparam logic [AW-1:0] MV = 13'h0531;
  localparam logic [BW-1:0] MB = 3'd2;

  logic clk = 0, rst_n = 0;
  logic cs_n, ras_n, cas_n, we_n, init_done;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .BA_W(BW), .CNT_W(8), .PWR_CYC(P), .RP_CYC(RP),
    .RFC_CYC(RFC), .MRD_CYC(MRD), .NUM_REF(NR), .MODE_VAL(MV), .MODE_BA(MB)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

  task automatic expect_bus(input logic [3:0] c, input logic [AW-1:0] a,
                            input logic [BW-1:0] b, input logic d, input string rq);
    logic [3:0] got = {cs_n, ras_n, cas_n, we_n};
    n_chk++;
    if (got !== c || addr !== a || ba !== b || init_done !== d) begin
      n_bad++;
      $display("FAIL %s: got cmd=%b addr=%h ba=%0d done=%b, expected cmd=%b addr=%h ba=%0d done=%b",
               rq, got, addr, ba, init_done, c, a, b, d);
    end
  endtask

  task automatic nops(input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      expect_bus(4'b0111, '0, '0, 1'b0, rq);
    end
  endtask

  // Expects reset released at a negedge just before the call.
  task automatic full_sequence;
    nops(P, "R3 power-up NOP");
    @(negedge clk); expect_bus(4'b0010, 13'h0400, '0, 1'b0, "R4 precharge-all");
    nops(RP, "R5 tRP wait");
    for (int r = 0; r < NR; r++) begin
      @(negedge clk); expect_bus(4'b0001, '0, '0, 1'b0, "R6 auto-refresh");
      nops(RFC, "R6 tRFC wait");
    end
    @(negedge clk); expect_bus(4'b0000, MV, MB, 1'b0, "R7 mode load");
    nops(MRD, "R8 tMRD wait");
    @(negedge clk); expect_bus(4'b0111, '0, '0, 1'b1, "R8 init_done rise");
  endtask

  task automatic t_reset_state;
    rst_n = 0;
    repeat (3) @(negedge clk);
    expect_bus(4'b0111, '0, '0, 1'b0, "R1 reset state");
    expect_bus(4'b0111, '0, '0, 1'b0, "R2 NOP encoding");
  endtask

  task automatic t_main;
    rst_n = 1;
    full_sequence();
  endtask

  task automatic t_hold_done;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      expect_bus(4'b0111, '0, '0, 1'b1, "R9 done held");
    end
  endtask

  task automatic t_mid_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (P + 3) @(negedge clk);
    rst_n = 0;
    #1 expect_bus(4'b0111, '0, '0, 1'b0, "R1 mid-sequence reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    full_sequence();
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_main();
    t_hold_done();
    t_mid_reset();
    t_hold_done();
    finish_run();
  end
endmodule